// File: doc/BRIEF.md
# Valley Pulse Qualifier

This block sits between a demagnetization comparator, which watches an auxiliary winding on a boost inductor, and the controller that decides when the power switch turns on again. After the gate turns off, the drain voltage rings. The comparator output toggles with that ringing. Each accepted high-to-low transition of the comparator marks a point just ahead of a local minimum of the drain-source voltage. The block turns each accepted transition into a one-cycle valley pulse.

A transition is accepted only if the comparator stayed high without a break for a qualification time just before it. This rejects glitches. A programmable blanking window after turn-off hides the first ringing.

The block counts accepted valleys from each turn-off. It issues a start pulse on the valley that the selection input names, so a variable-frequency controller can skip early valleys. If no selected valley arrives within a programmable timeout, a forced start keeps switching alive. All pins are plain control and status signals. There is no data stream, so there is no handshake and no back-pressure.

Top module: `valley_pick`

## Requirements
- R1: `cmp_raw` passes through a two-flop synchronizer before qualification. A qualifying low level first present on `cmp_raw` at clock edge n is acted on at edge n+2, and `valley_pulse` is high in the cycle that follows edge n+2.
- R2: An accepted transition raises `valley_pulse` for exactly one cycle. A transition is accepted when the synchronized comparator goes from high to low after at least QUAL_CYC consecutive high samples that were all taken while armed.
- R3: A transition that follows fewer than QUAL_CYC consecutive armed high samples produces no `valley_pulse`.
- R4: `gate_off` is sampled high at edge E0. The synchronized comparator samples taken at edges E0+1 through E0+`blank_len` are ignored: they neither count toward the high time nor produce a pulse. High time counted before E0 is discarded.
- R5: `valley_count` reads 0 in the cycle after `gate_off` is sampled. It then rises by one with each `valley_pulse`, and saturates at its all-ones value.
- R6: `start_pulse` is raised with the `valley_pulse` whose new count equals `valley_sel`, where 1 means the first valley. After any start pulse, no further `valley_pulse` or `start_pulse` occurs until the next `gate_off`.
- R7: A `valley_sel` of 0 never selects a valley. Only the timeout can then start the next cycle.
- R8: If no selected valley has been accepted, `start_pulse` and `forced_pulse` are both high in the cycle that follows edge E0+`timeout_len`+1. A selected valley accepted at that same edge takes priority, and `forced_pulse` stays low.
- R9: While `rst_n` is low, and in the first cycle after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Asynchronous demagnetization comparator output, high while the auxiliary voltage is above its threshold |
| gate_off | input | 1 | One-cycle strobe at power-switch turn-off; starts a new valley hunt |
| blank_len | input | CNT_W | Blanking length in cycles after turn-off |
| timeout_len | input | CNT_W | Cycles after turn-off before a forced start |
| valley_sel | input | SEL_W | Valley that starts the next cycle (1 = first, 0 = none) |
| valley_pulse | output | 1 | One-cycle pulse per accepted valley |
| start_pulse | output | 1 | One-cycle request to turn the switch on |
| forced_pulse | output | 1 | High with start_pulse when the start came from the timeout |
| valley_count | output | SEL_W | Valleys accepted since the last turn-off |

## Verification
A high-time counter that is stuck, or cleared at the wrong time, shows up at the ports at the very next comparator fall. The fall either produces a pulse that should not exist, or it fails to produce one. The start pulse then moves to another valley or to the timeout instant, so the error is visible within one ringing period.

An elapsed counter that is off by one shifts both the blanking edge and the forced start by exactly that cycle, which the blanking sweep and the timeout cases measure. A valley counter that is not cleared or not incremented shows in `valley_count` one cycle after `gate_off`, and it shows again when the start lands on the wrong valley.

// File: rtl/valley_pkg.sv
package valley_pkg;
  // hunt phase of the sequencer
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_HUNT = 1'b1
  } hunt_e;
endpackage

// File: rtl/vp_sync.sv
module vp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/vp_hightime.sv
module vp_hightime #(
  parameter int QUAL_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic enable,
  input  logic clear,
  output logic qual_fall
);
  localparam int RW = $clog2(QUAL_CYC + 1);
  localparam logic [RW-1:0] QMAX = RW'(QUAL_CYC);

  logic [RW-1:0] run_q;

  // consecutive armed high samples, saturating at the qualification length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clear || !enable || !level) begin
      run_q <= '0;
    end else if (run_q != QMAX) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign qual_fall = enable && !level && (run_q == QMAX);
endmodule

// File: rtl/vp_sequencer.sv
module vp_sequencer
  import valley_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_off,
  input  logic             qual_fall,
  input  logic [CNT_W-1:0] blank_len,
  input  logic [CNT_W-1:0] timeout_len,
  input  logic [SEL_W-1:0] valley_sel,
  output logic             armed,
  output logic             valley_pulse,
  output logic             start_pulse,
  output logic             forced_pulse,
  output logic [SEL_W-1:0] valley_count
);
  localparam logic [CNT_W-1:0] EL_MAX  = '1;
  localparam logic [SEL_W-1:0] CNT_MAX = '1;

  hunt_e            phase_q;
  logic [CNT_W-1:0] elapsed_q;
  logic [SEL_W-1:0] cnt_nxt;
  logic             hit, sel_hit, expire;

  assign armed   = (phase_q == PH_HUNT) && (elapsed_q >= blank_len);
  assign hit     = armed && qual_fall;
  assign cnt_nxt = (valley_count == CNT_MAX) ? valley_count : valley_count + 1'b1;
  assign sel_hit = hit && (valley_sel != '0) && (cnt_nxt == valley_sel);
  assign expire  = (phase_q == PH_HUNT) && (elapsed_q == timeout_len) && !sel_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      elapsed_q    <= '0;
      valley_count <= '0;
      valley_pulse <= 1'b0;
      start_pulse  <= 1'b0;
      forced_pulse <= 1'b0;
    end else begin
      valley_pulse <= 1'b0;
      start_pulse  <= 1'b0;
      forced_pulse <= 1'b0;
      if (gate_off) begin
        phase_q      <= PH_HUNT;
        elapsed_q    <= '0;
        valley_count <= '0;
      end else if (phase_q == PH_HUNT) begin
        if (elapsed_q != EL_MAX) elapsed_q <= elapsed_q + 1'b1;
        if (hit) begin
          valley_pulse <= 1'b1;
          valley_count <= cnt_nxt;
        end
        if (sel_hit) begin
          start_pulse <= 1'b1;
          phase_q     <= PH_IDLE;
        end else if (expire) begin
          start_pulse  <= 1'b1;
          forced_pulse <= 1'b1;
          phase_q      <= PH_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/valley_pick.sv
module valley_pick #(
  parameter int QUAL_CYC    = 20,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16,
  parameter int SEL_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw,
  input  logic             gate_off,
  input  logic [CNT_W-1:0] blank_len,
  input  logic [CNT_W-1:0] timeout_len,
  input  logic [SEL_W-1:0] valley_sel,
  output logic             valley_pulse,
  output logic             start_pulse,
  output logic             forced_pulse,
  output logic [SEL_W-1:0] valley_count
);
  logic cmp_s;
  logic armed;
  logic qual_fall;

  vp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cmp_raw),
    .d_sync  (cmp_s)
  );

  vp_hightime #(.QUAL_CYC(QUAL_CYC)) u_high (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (cmp_s),
    .enable    (armed),
    .clear     (gate_off),
    .qual_fall (qual_fall)
  );

  vp_sequencer #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_off     (gate_off),
    .qual_fall    (qual_fall),
    .blank_len    (blank_len),
    .timeout_len  (timeout_len),
    .valley_sel   (valley_sel),
    .armed        (armed),
    .valley_pulse (valley_pulse),
    .start_pulse  (start_pulse),
    .forced_pulse (forced_pulse),
    .valley_count (valley_count)
  );
endmodule

// File: rtl/vp_checker.sv
module vp_checker #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_off,
  input logic             valley_pulse,
  input logic             start_pulse,
  input logic             forced_pulse,
  input logic [SEL_W-1:0] valley_count
);
  localparam logic [SEL_W-1:0] CMAX = '1;

  // R8
  forced_has_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forced_pulse |-> start_pulse);

  // R6
  sel_start_on_valley_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !forced_pulse) |-> valley_pulse);

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R5
  clear_on_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off |=> (valley_count == '0) && !start_pulse && !valley_pulse);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valley_pulse && $past(valley_count) != CMAX && !$past(gate_off))
      |-> valley_count == $past(valley_count) + 1'b1);

  // R2
  valley_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valley_pulse |=> !valley_pulse);
endmodule

bind valley_pick vp_checker #(.SEL_W(SEL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .gate_off     (gate_off),
  .valley_pulse (valley_pulse),
  .start_pulse  (start_pulse),
  .forced_pulse (forced_pulse),
  .valley_count (valley_count)
);

// File: tb/sim_valley_pick.sv
module sim_valley_pick;
  localparam int Q  = 4;
  localparam int CW = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_raw = 1'b0;
  logic gate_off = 1'b0;
  logic [CW-1:0] blank_len = '0;
  logic [CW-1:0] timeout_len = '0;
  logic [SW-1:0] valley_sel = '0;
  logic valley_pulse, start_pulse, forced_pulse;
  logic [SW-1:0] valley_count;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  valley_pick #(.QUAL_CYC(Q), .SYNC_STAGES(2), .CNT_W(CW), .SEL_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .gate_off(gate_off),
    .blank_len(blank_len), .timeout_len(timeout_len), .valley_sel(valley_sel),
    .valley_pulse(valley_pulse), .start_pulse(start_pulse),
    .forced_pulse(forced_pulse), .valley_count(valley_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pulse gate_off so it is sampled at edge E0; returns at the negedge after E0
  task automatic pulse_gate();
    @(negedge clk);
    cmp_raw  = 1'b0;
    gate_off = 1'b1;
    @(negedge clk);
    gate_off = 1'b0;
  endtask

  // rings: nr high bursts of h cycles, gaps of l, first high at raw index fst
  task automatic run_case(input int h, input int l, input int nr, input int fst,
                          input int blank, input int tmo, input int sel, input int len,
                          output int st_m, output int forced, output int npul,
                          output int nst, output int cnt);
    blank_len   = CW'(blank);
    timeout_len = CW'(tmo);
    valley_sel  = SW'(sel);
    pulse_gate();
    st_m = -1; forced = 0; npul = 0; nst = 0;
    for (int m = 1; m <= len; m++) begin
      int k;
      int off;
      k = (m - fst) / (h + l);
      off = (m - fst) % (h + l);
      cmp_raw = (m >= fst && k < nr && off < h);
      @(negedge clk);
      if (valley_pulse) npul++;
      if (start_pulse) begin
        nst++;
        if (st_m < 0) begin
          st_m = m;
          forced = forced_pulse;
        end
      end
    end
    cmp_raw = 1'b0;
    cnt = valley_count;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int st_m, forced, npul, nst, cnt;
    // R9 reset state
    repeat (3) @(negedge clk);
    check(!valley_pulse && !start_pulse && !forced_pulse && valley_count == 0,
          "R9 outputs during reset", {valley_pulse, start_pulse, forced_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!valley_pulse && !start_pulse && !forced_pulse && valley_count == 0,
          "R9 outputs after reset", {valley_pulse, start_pulse, forced_pulse}, 0);

    // R1 R2 R3 R6 R7 R8: sweep high length and valley selection
    for (int h = 1; h <= 6; h++) begin
      for (int sel = 0; sel <= 3; sel++) begin
        bit q;
        int em, ef, ep;
        q = (h >= Q);
        if (q && sel >= 1) begin
          em = 10 + (sel - 1) * (h + 3) + h + 2;
          ef = 0;
          ep = sel;
        end else begin
          em = 61;
          ef = 1;
          ep = q ? 3 : 0;
        end
        run_case(h, 3, 3, 10, 6, 60, sel, 80, st_m, forced, npul, nst, cnt);
        check(st_m == em, "R1 R6 R8 start cycle", st_m, em);
        check(forced == ef, "R7 R8 forced flag", forced, ef);
        check(npul == ep, "R2 R3 valley pulse count", npul, ep);
        check(cnt == ep, "R5 valley_count", cnt, ep);
        check(nst == 1, "R6 single start", nst, 1);
      end
    end

    // R4 blanking sweep: comparator high on raw 2..11, fall at 12
    for (int b = 0; b <= 14; b++) begin
      int lo, em;
      lo = (b + 1 > 4) ? b + 1 : 4;
      em = ((14 - lo) >= Q) ? 14 : 61;
      run_case(10, 3, 1, 2, b, 60, 1, 80, st_m, forced, npul, nst, cnt);
      check(st_m == em, "R4 blanking start cycle", st_m, em);
      check(npul == (em == 14 ? 1 : 0), "R4 blanking valley count", npul, em == 14 ? 1 : 0);
    end

    // R5 gate_off clears count (count is nonzero here from prior case? force one)
    run_case(5, 3, 3, 10, 6, 60, 0, 70, st_m, forced, npul, nst, cnt);
    check(cnt == 3, "R5 count before clear", cnt, 3);
    pulse_gate();
    check(valley_count == 0, "R5 count cleared by gate_off", valley_count, 0);

    // R5 saturation: 9 valleys, 3-bit counter
    run_case(4, 3, 9, 10, 6, 100, 0, 110, st_m, forced, npul, nst, cnt);
    check(npul == 9, "R5 pulses past saturation", npul, 9);
    check(cnt == 7, "R5 saturated count", cnt, 7);
    check(st_m == 101 && forced == 1, "R7 sel zero forced start", st_m, 101);

    // R8 timeout of zero
    run_case(6, 3, 3, 10, 6, 0, 1, 40, st_m, forced, npul, nst, cnt);
    check(st_m == 1 && forced == 1, "R8 zero timeout", st_m, 1);
    check(npul == 0, "R6 no valleys after start", npul, 0);

    // R8 priority: selected valley at the timeout edge wins
    run_case(5, 3, 3, 10, 6, 16, 1, 40, st_m, forced, npul, nst, cnt);
    check(st_m == 17 && forced == 0, "R8 valley beats timeout", st_m * 10 + forced, 170);
    run_case(5, 3, 3, 10, 6, 15, 1, 40, st_m, forced, npul, nst, cnt);
    check(st_m == 16 && forced == 1, "R8 timeout one cycle early", st_m * 10 + forced, 161);
    check(npul == 0, "R6 valley after forced start ignored", npul, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule